// File: doc/BRIEF.md
# Request Decimator with Request Tallies

This block sits between a set of request sources and a shared serial command channel, and reduces the number of requests on each channel. Each channel has a ratio N that the host sets. The channel passes on one request and then drops the next N−1. Every request that arrives is also added to a 16-bit tally for its channel. The host can read that tally and clear it.

A request is one clock cycle with the channel's `req_in` bit high. Holding the bit high for k cycles gives k requests. A forwarded request shows up as a one-cycle pulse on `fwd_out`, one clock after the request.

The host sees the block through a flat register port. The upper two address bits choose the kind of access, and the lower bits choose the channel:

- Kind 0 reads or writes the channel's ratio.
- Kind 1 reads the channel's tally. A write to kind 1 clears that channel.
- Kind 2 clears every channel when written.

Reads are combinational. Writes take effect at the next clock edge.

Top module: `req_decimator`

## Requirements
- R1: After reset, `fwd_out` is all zero, every tally reads 0 and every ratio reads 1.
- R2: Channels work independently. After a restart the first request on a channel is forwarded and the next N−1 are suppressed, repeating with period N. A forwarded request gives a one-cycle `fwd_out` pulse in the cycle after the request, and no pulse ever appears without a request in the cycle before.
- R3: A ratio of 1 forwards every request, and a ratio of 0 behaves exactly like 1.
- R4: The ratio is 16 bits wide. With 65535, one request in 65535 is forwarded.
- R5: The tally of a channel goes up by one for every accepted request, wraps from 65535 to 0, and stays unchanged in cycles without one.
- R6: A kind-0 write (address bits [5:4] = 0, bits [3:0] = channel) stores the ratio. A kind-0 read returns it.
- R7: A kind-1 write to a channel zeroes its tally and restarts its decimation, so the next request is forwarded. A kind-2 write (bits [5:4] = 2) does the same for all channels. Kind-1 reads return the tally.
- R8: A clear in the same cycle as a request wins. That request is neither counted nor forwarded.
- R9: A kind-0 write restarts that channel's decimation, so the next request after the write is forwarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_in | input | 16 | Request bit per channel. Each cycle the bit is high counts as one request |
| fwd_out | output | 16 | Forwarded-request pulse per channel, one cycle after the request |
| host_wr | input | 1 | Host write strobe |
| host_addr | input | 6 | Bits [5:4] give the access kind, bits [3:0] give the channel |
| host_wdata | input | 16 | Write data, used by ratio writes |
| host_rdata | output | 16 | Read data for `host_addr`: the ratio for kind 0, the tally for kind 1, 0 otherwise |

## Verification
The hardest situations to reach are the tally wrap and the largest ratio, because both need tens of thousands of requests on a single channel. The bench gets there by holding one request bit high for 65537 consecutive cycles with the ratio at 65535. It expects exactly two forwarded pulses and a final tally of 1. A second hard case is a clear landing in the same cycle as a request. The bench issues the host write and the request on the same edge, then checks three things: no pulse appears, the tally is zero, and the next request is forwarded.

// File: rtl/decim_pkg.sv
package decim_pkg;

  localparam int unsigned KIND_W = 2;

  typedef enum logic [KIND_W-1:0] {
    KIND_RATIO = 2'd0,
    KIND_TALLY = 2'd1,
    KIND_ALL   = 2'd2,
    KIND_NONE  = 2'd3
  } acc_kind_e;

  // A zero ratio behaves like one.
  function automatic logic [31:0] eff_ratio(input logic [31:0] r);
    return (r == 32'd0) ? 32'd1 : r;
  endfunction

  // Phase after one more accepted request; returns to zero after N requests.
  function automatic logic [31:0] next_phase(input logic [31:0] p, input logic [31:0] r);
    logic [32:0] inc;
    inc = {1'b0, p} + 33'd1;
    return (inc >= {1'b0, eff_ratio(r)}) ? 32'd0 : inc[31:0];
  endfunction

  // Tally step with wrap at the counter width.
  function automatic logic [31:0] tally_step(input logic [31:0] t, input int unsigned w);
    logic [31:0] mask;
    mask = (w >= 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
    return (t + 32'd1) & mask;
  endfunction

endpackage

// File: rtl/decim_lane.sv
module decim_lane
  import decim_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic             clr,
  input  logic             ratio_wr,
  input  logic [CNT_W-1:0] ratio,
  output logic             accept,
  output logic             fire,
  output logic [CNT_W-1:0] tally
);

  logic [CNT_W-1:0] phase_q;
  logic [CNT_W-1:0] phase_nx;
  logic [CNT_W-1:0] tally_nx;

  assign accept   = req & ~clr;
  assign phase_nx = CNT_W'(next_phase(32'(phase_q), 32'(ratio)));
  assign tally_nx = CNT_W'(tally_step(32'(tally), CNT_W));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= '0;
      tally   <= '0;
      fire    <= 1'b0;
    end else begin
      fire <= accept && (phase_q == '0);
      if (clr) begin
        phase_q <= '0;
        tally   <= '0;
      end else begin
        if (ratio_wr) begin
          phase_q <= '0;
        end else if (accept) begin
          phase_q <= phase_nx;
        end
        if (accept) begin
          tally <= tally_nx;
        end
      end
    end
  end

endmodule

// File: rtl/decim_host_if.sv
module decim_host_if
  import decim_pkg::*;
#(
  parameter int unsigned NUM_CH = 16,
  parameter int unsigned CNT_W  = 16,
  localparam int unsigned CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int unsigned ADDR_W = CH_W + KIND_W
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          host_wr,
  input  logic [ADDR_W-1:0]             host_addr,
  input  logic [CNT_W-1:0]              host_wdata,
  input  logic [NUM_CH-1:0][CNT_W-1:0]  tally_bus,
  output logic [CNT_W-1:0]              host_rdata,
  output logic [NUM_CH-1:0][CNT_W-1:0]  ratio_bus,
  output logic [NUM_CH-1:0]             ratio_wr_vec,
  output logic [NUM_CH-1:0]             clr_vec
);

  acc_kind_e        kind;
  logic [CH_W-1:0]  ch_sel;
  logic             ch_ok;

  assign kind   = acc_kind_e'(host_addr[ADDR_W-1:CH_W]);
  assign ch_sel = host_addr[CH_W-1:0];
  assign ch_ok  = (32'(ch_sel) < NUM_CH);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_dec
    logic hit;
    assign hit             = ch_ok && (32'(ch_sel) == c);
    assign ratio_wr_vec[c] = host_wr && (kind == KIND_RATIO) && hit;
    assign clr_vec[c]      = host_wr && (((kind == KIND_TALLY) && hit) || (kind == KIND_ALL));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ratio_bus[c] <= CNT_W'(1);
      end else if (ratio_wr_vec[c]) begin
        ratio_bus[c] <= host_wdata;
      end
    end
  end

  always_comb begin
    host_rdata = '0;
    if (ch_ok) begin
      unique case (kind)
        KIND_RATIO: host_rdata = ratio_bus[ch_sel];
        KIND_TALLY: host_rdata = tally_bus[ch_sel];
        default:    host_rdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/req_decimator.sv
module req_decimator
  import decim_pkg::*;
#(
  parameter int unsigned NUM_CH = 16,
  parameter int unsigned CNT_W  = 16,
  localparam int unsigned CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int unsigned ADDR_W = CH_W + KIND_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] req_in,
  output logic [NUM_CH-1:0] fwd_out,
  input  logic              host_wr,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [CNT_W-1:0]  host_wdata,
  output logic [CNT_W-1:0]  host_rdata
);

  logic [NUM_CH-1:0][CNT_W-1:0] tally_bus;
  logic [NUM_CH-1:0][CNT_W-1:0] ratio_bus;
  logic [NUM_CH-1:0]            ratio_wr_vec;
  logic [NUM_CH-1:0]            clr_vec;
  logic [NUM_CH-1:0]            acc_vec;

  decim_host_if #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_host (
    .clk          (clk),
    .rst_n        (rst_n),
    .host_wr      (host_wr),
    .host_addr    (host_addr),
    .host_wdata   (host_wdata),
    .tally_bus    (tally_bus),
    .host_rdata   (host_rdata),
    .ratio_bus    (ratio_bus),
    .ratio_wr_vec (ratio_wr_vec),
    .clr_vec      (clr_vec)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_lane
    decim_lane #(.CNT_W(CNT_W)) u_lane (
      .clk      (clk),
      .rst_n    (rst_n),
      .req      (req_in[c]),
      .clr      (clr_vec[c]),
      .ratio_wr (ratio_wr_vec[c]),
      .ratio    (ratio_bus[c]),
      .accept   (acc_vec[c]),
      .fire     (fwd_out[c]),
      .tally    (tally_bus[c])
    );
  end

endmodule

// File: rtl/req_decimator_chk.sv
module req_decimator_chk #(
  parameter int unsigned NUM_CH = 16,
  parameter int unsigned CNT_W  = 16
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic [NUM_CH-1:0]            req_in,
  input logic [NUM_CH-1:0]            fwd_out,
  input logic [NUM_CH-1:0]            clr_vec,
  input logic [NUM_CH-1:0]            acc_vec,
  input logic [NUM_CH-1:0][CNT_W-1:0] ratio_bus,
  input logic [NUM_CH-1:0][CNT_W-1:0] tally_bus
);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    assert_fwd_needs_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
      fwd_out[c] |-> $past(req_in[c]));

    assert_pass_through_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_vec[c] && (ratio_bus[c] <= CNT_W'(1))) |=> fwd_out[c]);

    assert_tally_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
      acc_vec[c] |=> (tally_bus[c] == CNT_W'($past(tally_bus[c]) + 1'b1)));

    assert_tally_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!acc_vec[c] && !clr_vec[c]) |=> $stable(tally_bus[c]));

    assert_clear_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      clr_vec[c] |=> (tally_bus[c] == '0));

    assert_clear_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_vec[c] && req_in[c]) |=> !fwd_out[c]);
  end

endmodule

bind req_decimator req_decimator_chk #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_in    (req_in),
  .fwd_out   (fwd_out),
  .clr_vec   (clr_vec),
  .acc_vec   (acc_vec),
  .ratio_bus (ratio_bus),
  .tally_bus (tally_bus)
);

// File: tb/req_decimator_bench.sv
module req_decimator_bench;

  localparam int NCH = 16;
  localparam int CW  = 16;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [NCH-1:0] req_in = '0;
  logic [NCH-1:0] fwd_out;
  logic           host_wr = 1'b0;
  logic [5:0]     host_addr = '0;
  logic [CW-1:0]  host_wdata = '0;
  logic [CW-1:0]  host_rdata;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  req_decimator u_req_decimator (
    .clk(clk), .rst_n(rst_n), .req_in(req_in), .fwd_out(fwd_out),
    .host_wr(host_wr), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_rdata(host_rdata)
  );

  // Vector: [35:32] channel, [31:16] ratio, [15:8] requests, [7:0] expected forwards
  localparam logic [35:0] VEC [8] = '{
    {4'd0, 16'd1,     8'd5,  8'd5},
    {4'd1, 16'd2,     8'd7,  8'd4},
    {4'd2, 16'd3,     8'd9,  8'd3},
    {4'd3, 16'd0,     8'd4,  8'd4},
    {4'd4, 16'd5,     8'd1,  8'd1},
    {4'd5, 16'd4,     8'd10, 8'd3},
    {4'd6, 16'd7,     8'd15, 8'd3},
    {4'd7, 16'd65535, 8'd3,  8'd1}
  };

  function automatic logic [5:0] adr(input int kind, input int ch);
    return {kind[1:0], ch[3:0]};
  endfunction

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  task automatic hwrite(input int kind, input int ch, input int data);
    @(negedge clk);
    host_wr = 1'b1; host_addr = adr(kind, ch); host_wdata = data[CW-1:0];
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic hread(input int kind, input int ch, output int val);
    @(negedge clk);
    host_addr = adr(kind, ch);
    #1 val = int'(host_rdata);
  endtask

  // One request cycle on a channel; returns the forward pulse seen after it.
  task automatic pulse(input int ch, output bit f);
    @(negedge clk);
    req_in[ch] = 1'b1;
    @(negedge clk);
    req_in[ch] = 1'b0;
    f = fwd_out[ch];
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int v;
    bit f;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk(fwd_out == '0, "R1 fwd_out idle", int'(fwd_out), 0);
    for (int c = 0; c < NCH; c++) begin
      hread(1, c, v); chk(v == 0, "R1 tally zero", v, 0);
      hread(0, c, v); chk(v == 1, "R1 ratio one", v, 1);
    end

    // Vector table: R2, R3, R4, R5, R6
    for (int i = 0; i < 8; i++) begin
      int ch, rat, nreq, efwd, eff, got;
      ch = int'(VEC[i][35:32]); rat = int'(VEC[i][31:16]);
      nreq = int'(VEC[i][15:8]); efwd = int'(VEC[i][7:0]);
      eff = (rat == 0) ? 1 : rat;
      got = 0;
      hwrite(0, ch, rat);
      hread(0, ch, v); chk(v == rat, "R6 ratio readback", v, rat);
      for (int k = 0; k < nreq; k++) begin
        pulse(ch, f);
        chk(f == ((k % eff) == 0), "R2 R3 forward pattern", int'(f), int'((k % eff) == 0));
        if (f) got++;
      end
      chk(got == efwd, "R2 R4 forward count", got, efwd);
      hread(1, ch, v); chk(v == nreq, "R5 tally", v, nreq);
    end

    // R2 independence: all channels request together
    hwrite(2, 0, 0);
    @(negedge clk); req_in = '1;
    @(negedge clk); req_in = '0;
    chk(fwd_out == '1, "R2 all channels first forward", int'(fwd_out), 16'hFFFF);
    @(negedge clk); req_in = '1;
    @(negedge clk); req_in = '0;
    // channels with ratio 1 or 0 (0,3 and 8..15) forward again
    chk(fwd_out == 16'hFF09, "R2 second round", int'(fwd_out), 16'hFF09);

    // R7 clear all
    hwrite(2, 0, 0);
    for (int c = 0; c < 8; c++) begin
      hread(1, c, v); chk(v == 0, "R7 clear all", v, 0);
    end

    // R8 clear colliding with request
    hwrite(0, 2, 3);
    pulse(2, f); chk(f == 1'b1, "R8 setup first", int'(f), 1);
    pulse(2, f); chk(f == 1'b0, "R8 setup second", int'(f), 0);
    @(negedge clk);
    host_wr = 1'b1; host_addr = adr(1, 2); req_in[2] = 1'b1;
    @(negedge clk);
    host_wr = 1'b0; req_in[2] = 1'b0;
    chk(fwd_out[2] == 1'b0, "R8 no forward on clear", int'(fwd_out[2]), 0);
    hread(1, 2, v); chk(v == 0, "R8 request not counted", v, 0);
    pulse(2, f); chk(f == 1'b1, "R7 restart after clear", int'(f), 1);
    hread(1, 2, v); chk(v == 1, "R7 tally after clear", v, 1);

    // R9 ratio write restarts phase
    hwrite(0, 1, 4);
    pulse(1, f); chk(f == 1'b1, "R9 first", int'(f), 1);
    pulse(1, f); chk(f == 1'b0, "R9 suppressed", int'(f), 0);
    hwrite(0, 1, 2);
    pulse(1, f); chk(f == 1'b1, "R9 restart on ratio write", int'(f), 1);

    // R4 R5 wrap and largest ratio on channel 15
    begin
      int n;
      n = 0;
      hwrite(0, 15, 65535);
      hwrite(1, 15, 0);
      @(negedge clk); req_in[15] = 1'b1;
      for (int k = 0; k < 65537; k++) begin
        @(negedge clk);
        if (fwd_out[15]) n++;
      end
      req_in[15] = 1'b0;
      chk(n == 2, "R4 max ratio forwards", n, 2);
      hread(1, 15, v); chk(v == 1, "R5 tally wrap", v, 1);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule